// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable stand-in for a 16-bit asynchronous static memory. The memory has two byte lanes, and each lane has its own active-low enable. The chip select, write strobe and output enable are also active low. Every pin arrives asynchronously, so the block samples all of them on a fast internal clock through a two-stage synchronizer. It then decodes each sampled cycle into one of four operating modes.

A read returns the addressed word on the lanes whose enables are low. The block also raises one drive-enable bit per lane, which the surrounding pad logic uses to control a tri-state bus. A write lasts as long as both the chip select and the write strobe are low. It is committed when that overlap ends, whichever of the two pins rises first. Only the lanes whose enables were low are written. A status flag shows when the memory is idle, either because the chip is not selected or because no byte lane is enabled.

The storage depth is set by an address-width parameter. A full-size instance uses `ADDR_W = 17`. The default is kept small so that elaboration stays cheap.

Top module: `bytelane_sram`

## Requirements
- R1: While `rstN` is low and right after reset, `dataOut` is 0, `laneDrive` is 0, `opMode` is 0 and `standby` is 1.
- R2: Every input passes through two synchronizing flops. A pin change made between clock edges therefore reaches the outputs on the third rising edge after it, and not on an earlier one.
- R3: `opMode` is decoded from the sampled pins in this priority order:
  - 0 (idle) when the chip select is high, or when both byte-lane enables are high;
  - otherwise 3 (write) when the write strobe is low;
  - otherwise 1 (outputs off) when the output enable is high;
  - otherwise 2 (read).
- R4: `standby` is 1 exactly when `opMode` is 0. The outputs-off mode (chip selected, write high, output enable high) is active and is not standby.
- R5: In read mode, `laneDrive[0]` is the inverse of the low-lane enable and `laneDrive[1]` is the inverse of the high-lane enable. A driven lane carries its stored byte: bits 7:0 for the low lane and bits 15:8 for the high lane.
- R6: `laneDrive` is 0 in every mode other than read. Any lane that is not driven reads as zero on `dataOut`.
- R7: A write is committed only when the overlap of chip select low and write strobe low ends. Either pin rising ends it. Memory is never updated while the overlap lasts.
- R8: A committed write updates only the lanes whose enables were low in the last sampled cycle of the overlap. The other lane keeps its contents, and with both lanes disabled nothing changes.
- R9: A write uses the address and data sampled in the last cycle before the terminating edge. Address or data changes made together with that edge have no effect.
- R10: A read of the word being committed, in the same cycle as the commit, returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipEnN | input | 1 | Chip select, active low |
| writeEnN | input | 1 | Write strobe, active low |
| outEnN | input | 1 | Output enable, active low |
| lowByteEnN | input | 1 | Low byte lane enable, active low |
| highByteEnN | input | 1 | High byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Read data, zero on lanes not driven |
| laneDrive | output | 2 | Per-lane bus drive enable (bit 0 = low lane) |
| opMode | output | 2 | Decoded mode: 0 idle, 1 outputs off, 2 read, 3 write |
| standby | output | 1 | Idle / power-down indication |

## Verification
The bench checks writes ended by the chip select and writes ended by the write strobe. A design that watched only one of these pins would lose the other kind of write. Each write changes the address and data together with its terminating edge. A design that latched the values after that edge would corrupt the neighbouring word, which the bench pre-loads with a known value so the damage shows. Partial-lane writes and a write with no lane enabled expose a missing byte mask. A read of the word being committed, in the same cycle as the commit, exposes a design without forwarding: it would return the stale word for one cycle. The bench also checks the outputs-off mode, which a careless decoder might merge with standby.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_OUTOFF = 2'd1,
    MODE_READ   = 2'd2,
    MODE_WRITE  = 2'd3
  } sramMode_e;

  typedef struct packed {
    logic chipN;
    logic writeN;
    logic outN;
    logic highN;
    logic lowN;
  } ctlPins_t;

  localparam ctlPins_t PINS_IDLE = '{chipN: 1'b1, writeN: 1'b1, outN: 1'b1,
                                     highN: 1'b1, lowN: 1'b1};

  typedef struct packed {
    logic             commit;
    logic [LANES-1:0] laneWrite;
    logic [LANES-1:0] laneRead;
  } dpStrobe_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import bls_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlPins_t                pinsIn,
  output dpStrobe_t               stb,
  output sramMode_e               opMode,
  output logic                    standby,
  output logic [LANES-1:0]        laneDrive
);
  ctlPins_t         ctlS1, ctlS2;
  logic             wrPrev;
  logic [LANES-1:0] lanePrev;
  logic [LANES-1:0] laneS2;
  logic             wrS2;
  sramMode_e        modeNext;

  // two-flop synchronizer on every control pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlS1 <= PINS_IDLE;
      ctlS2 <= PINS_IDLE;
    end else begin
      ctlS1 <= pinsIn;
      ctlS2 <= ctlS1;
    end
  end

  assign laneS2 = {~ctlS2.highN, ~ctlS2.lowN};
  assign wrS2   = ~ctlS2.chipN & ~ctlS2.writeN;

  // one cycle of history to find the end of the write overlap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b0;
      lanePrev <= '0;
    end else begin
      wrPrev   <= wrS2;
      lanePrev <= laneS2;
    end
  end

  always_comb begin
    if (ctlS2.chipN || (laneS2 == '0)) modeNext = MODE_IDLE;
    else if (!ctlS2.writeN)            modeNext = MODE_WRITE;
    else if (ctlS2.outN)               modeNext = MODE_OUTOFF;
    else                               modeNext = MODE_READ;
  end

  assign stb.commit    = wrPrev & ~wrS2;
  assign stb.laneWrite = lanePrev;
  assign stb.laneRead  = (modeNext == MODE_READ) ? laneS2 : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opMode    <= MODE_IDLE;
      standby   <= 1'b1;
      laneDrive <= '0;
    end else begin
      opMode    <= modeNext;
      standby   <= (modeNext == MODE_IDLE);
      laneDrive <= stb.laneRead;
    end
  end

  // R7: a commit is a single-cycle event at the end of an overlap
  p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !stb.commit);
  // R4: idle never drives the bus
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (laneDrive == '0));
  // R6: bus stays released during a write
  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_WRITE) |-> (laneDrive == '0));
  // R5: drive only in read mode
  p_drive_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (laneDrive != '0) |-> (opMode == MODE_READ));
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import bls_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  dpStrobe_t         stb,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrS1, addrS2, addrPrev;
  logic [DATA_W-1:0] dataS1, dataS2, dataPrev;
  logic              sameWord;

  // address and data follow the same two-stage path as the controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS1   <= '0;
      addrS2   <= '0;
      addrPrev <= '0;
      dataS1   <= '0;
      dataS2   <= '0;
      dataPrev <= '0;
    end else begin
      addrS1   <= addrIn;
      addrS2   <= addrS1;
      addrPrev <= addrS2;
      dataS1   <= dataIn;
      dataS2   <= dataS1;
      dataPrev <= dataS2;
    end
  end

  assign sameWord = (addrPrev == addrS2);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic              laneHit;
    logic [LANE_W-1:0] laneVal;

    always_ff @(posedge clk) begin
      if (stb.commit && stb.laneWrite[g])
        laneMem[addrPrev] <= dataPrev[g*LANE_W +: LANE_W];
    end

    assign laneHit = stb.commit & stb.laneWrite[g] & sameWord;
    assign laneVal = laneHit ? dataPrev[g*LANE_W +: LANE_W] : laneMem[addrS2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dataOut[g*LANE_W +: LANE_W] <= '0;
      else       dataOut[g*LANE_W +: LANE_W] <= stb.laneRead[g] ? laneVal : '0;
    end

    // R6: a lane not read this cycle shows zero next cycle
    p_undriven_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
      !stb.laneRead[g] |=> (dataOut[g*LANE_W +: LANE_W] == '0));
  end

  // R10: full-word read during its own commit returns the new word
  p_forward_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && sameWord && (stb.laneWrite == '1) && (stb.laneRead == '1))
      |=> (dataOut == $past(dataPrev)));
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              writeEnN,
  input  logic              outEnN,
  input  logic              lowByteEnN,
  input  logic              highByteEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic [1:0]        laneDrive,
  output logic [1:0]        opMode,
  output logic              standby
);
  ctlPins_t  pins;
  dpStrobe_t stb;
  sramMode_e modeQ;

  assign pins = '{chipN: chipEnN, writeN: writeEnN, outN: outEnN,
                  highN: highByteEnN, lowN: lowByteEnN};

  sram_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pinsIn    (pins),
    .stb       (stb),
    .opMode    (modeQ),
    .standby   (standby),
    .laneDrive (laneDrive)
  );

  sram_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addr),
    .dataIn  (dataIn),
    .stb     (stb),
    .dataOut (dataOut)
  );

  assign opMode = modeQ;
endmodule

// File: tb/sim_bytelane_sram.sv
module sim_bytelane_sram;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, weN = 1'b1, oeN = 1'b1, lbN = 1'b1, hbN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   dataOut;
  logic [1:0]    laneDrive, opMode;
  logic          standby;

  int  nChecks = 0, nFails = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .chipEnN(ceN), .writeEnN(weN), .outEnN(oeN),
    .lowByteEnN(lbN), .highByteEnN(hbN), .addr(addr), .dataIn(wdata),
    .dataOut(dataOut), .laneDrive(laneDrive), .opMode(opMode), .standby(standby)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  typedef struct {bit ce, we, oe, lb, hb; int a; logic [15:0] d;} pinSnap_t;
  pinSnap_t    hist [4];
  logic [15:0] refMem   [int];
  bit   [1:0]  refKnown [int];
  int          expMode, expStandby, expDrive;
  logic [15:0] expData;
  bit   [1:0]  expKnown;

  function automatic pinSnap_t idleSnap();
    pinSnap_t s;
    s.ce = 1; s.we = 1; s.oe = 1; s.lb = 1; s.hb = 1; s.a = 0; s.d = '0;
    return s;
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) hist[i] = idleSnap();
    expMode = 0; expStandby = 1; expDrive = 0; expData = '0; expKnown = '0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) hist[i] = idleSnap();
      expMode = 0; expStandby = 1; expDrive = 0; expData = '0; expKnown = '0;
    end else begin
      pinSnap_t cur, prv;
      bit actC, actP;
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0].ce = ceN; hist[0].we = weN; hist[0].oe = oeN;
      hist[0].lb = lbN; hist[0].hb = hbN; hist[0].a = int'(addr); hist[0].d = wdata;
      cur = hist[2]; prv = hist[3];
      actC = !cur.ce && !cur.we;
      actP = !prv.ce && !prv.we;
      if (actP && !actC) begin
        if (!refMem.exists(prv.a)) begin refMem[prv.a] = '0; refKnown[prv.a] = '0; end
        if (!prv.lb) begin refMem[prv.a][7:0]  = prv.d[7:0];  refKnown[prv.a][0] = 1; end
        if (!prv.hb) begin refMem[prv.a][15:8] = prv.d[15:8]; refKnown[prv.a][1] = 1; end
      end
      if (cur.ce || (cur.lb && cur.hb)) expMode = 0;
      else if (!cur.we)                 expMode = 3;
      else if (cur.oe)                  expMode = 1;
      else                              expMode = 2;
      expStandby = (expMode == 0);
      expDrive   = (expMode == 2) ? {!cur.hb, !cur.lb} : 0;
      expData    = refMem.exists(cur.a) ? refMem[cur.a] : '0;
      expKnown   = refKnown.exists(cur.a) ? refKnown[cur.a] : 2'b00;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 mode", opMode, expMode);
      chk("R4 standby", standby, expStandby);
      chk("R6 lane drive", laneDrive, expDrive);
      for (int g = 0; g < 2; g++) begin
        if (!expDrive[g])
          chk("R6 undriven lane zero", dataOut[g*8 +: 8], 0);
        else if (expKnown[g])
          chk("R8 lane data", dataOut[g*8 +: 8], expData[g*8 +: 8]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic goIdle();
    ceN = 1; weN = 1; oeN = 1; lbN = 1; hbN = 1;
  endtask

  task automatic doWrite(int a, logic [15:0] d, logic lo, logic hi, bit byChip);
    @(negedge clk);
    ceN = 0; weN = 0; oeN = 1; lbN = lo; hbN = hi; addr = AW'(a); wdata = d;
    repeat (3) @(negedge clk);
    if (byChip) ceN = 1; else weN = 1;
    addr = AW'(a ^ 1); wdata = ~d;            // must be ignored (R9)
    repeat (3) @(negedge clk);
    goIdle();
    repeat (2) @(negedge clk);
  endtask

  task automatic readCheck(int a, logic lo, logic hi, logic [15:0] exp, string tag);
    @(negedge clk);
    ceN = 0; weN = 1; oeN = 0; lbN = lo; hbN = hi; addr = AW'(a);
    repeat (3) @(negedge clk);
    chk({tag, " read data"}, dataOut, exp);
    chk("R5 read lane drive", laneDrive, {~hi, ~lo});
    goIdle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset dataOut", dataOut, 0);
    chk("R1 reset laneDrive", laneDrive, 0);
    chk("R1 reset opMode", opMode, 0);
    chk("R1 reset standby", standby, 1);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R2 latency: outputs-off mode appears on the third edge
    ceN = 0; weN = 1; oeN = 1; lbN = 0; hbN = 0;
    repeat (2) @(negedge clk);
    chk("R2 no early change", opMode, 0);
    @(negedge clk);
    chk("R2 third edge", opMode, 1);
    chk("R4 outputs-off not standby", standby, 0);
    chk("R6 outputs-off no drive", laneDrive, 0);
    goIdle();
    repeat (3) @(negedge clk);
    chk("R4 deselected standby", standby, 1);

    // R7 / R9: both termination styles, neighbour word guarded
    doWrite(4, 16'h0000, 0, 0, 1'b0);
    doWrite(5, 16'hA55A, 0, 0, 1'b0);
    doWrite(9, 16'h1234, 0, 0, 1'b1);
    readCheck(5, 0, 0, 16'hA55A, "R7 strobe-ended");
    readCheck(9, 0, 0, 16'h1234, "R7 select-ended");
    readCheck(4, 0, 0, 16'h0000, "R9 neighbour untouched");

    // R8 byte masks
    doWrite(5, 16'hFF77, 0, 1, 1'b0);
    readCheck(5, 0, 0, 16'hA577, "R8 low lane only");
    doWrite(5, 16'h3CFF, 1, 0, 1'b1);
    readCheck(5, 0, 0, 16'h3C77, "R8 high lane only");
    doWrite(5, 16'h0000, 1, 1, 1'b0);
    readCheck(5, 0, 0, 16'h3C77, "R8 no lane enabled");
    readCheck(5, 0, 1, 16'h0077, "R5 low lane read");
    readCheck(5, 1, 0, 16'h3C00, "R5 high lane read");

    // R10 read during commit
    @(negedge clk);
    ceN = 0; oeN = 0; weN = 0; lbN = 0; hbN = 0; addr = 7; wdata = 16'hBEEF;
    repeat (3) @(negedge clk);
    weN = 1;
    repeat (3) @(negedge clk);
    chk("R10 forwarded read", dataOut, 16'hBEEF);
    goIdle();
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule